// File: doc/BRIEF.md
# Oscillator Edge-Count Temperature Digitizer

This block converts the rising edges of a temperature-dependent oscillator into a digital code. A 10-bit edge counter runs on the oscillator signal itself and is never cleared. Its value crosses into the reference clock domain as a Gray code. There, a register captures it on every reference edge, and the block takes the modulo-1024 difference between consecutive captures. Because the counter keeps running, the quantization left over from one window carries into the next, so the differences have first-order noise shaping.

A window controller adds a selectable number of consecutive differences, from 1 to 16, into one wide result. It then raises a one-cycle valid strobe. Longer windows give finer resolution at a lower update rate. The controller is a two-state machine. `ST_PRIME` is entered on reset and lasts one reference cycle. In that cycle the first difference is thrown away and the window length is latched. The transition PRIME->ACCUM is unconditional. `ST_ACCUM` then adds one difference per cycle. On the ACCUM->ACCUM wrap transition (the cycle that consumes the last difference of a window), the block emits the result, clears the sum and latches the window length again.

Top module: `osc_count_digitizer`

## Requirements
- R1: The oscillator domain counts every rising edge of `osc_i` in a 10-bit counter that has no reset and wraps from 1023 to 0.
- R2: The count reaches the reference domain as a Gray code through two synchronizing flops and is converted back to binary. The captured value at reference edge k equals the number of oscillator edges completed before reference edge k-2, modulo 1024.
- R3: Each raw difference is the current capture minus the previous capture, modulo 1024. A counter wrap between captures still yields the true edge count, provided fewer than 1024 edges occur per reference cycle.
- R4: After reset is released, the first reference edge is spent in `ST_PRIME`. It adds nothing and emits nothing, and the next edge begins the first window in `ST_ACCUM`.
- R5: `win_len_i` selects the window length N. A value of 0 acts as 1, values above 16 act as 16, and 1 to 16 are used as given.
- R6: Let E(k) be the number of oscillator rising edges completed before reference edge k. A window ends at edge t. At that edge `temp_vld_o` goes high for one cycle, and `temp_code_o` becomes E(t-3) - E(t-3-N). This is the sum of the last N raw differences.
- R7: The sum restarts from zero after each result, and the next window begins on the very next reference edge, so consecutive windows are contiguous.
- R8: N is latched only at the start of a window: on the PRIME edge and on each edge that emits a result. A change of `win_len_i` inside a window does not alter that window.
- R9: While reset is asserted, `temp_code_o` is 0 and `temp_vld_o` is 0. `temp_code_o` changes only on an edge where `temp_vld_o` rises.
- R10: `temp_code_o` is 14 bits wide and holds window sums above 1023 (up to 16 x 1023) without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_i | input | 1 | Full-swing oscillator signal; its rising edges are counted |
| ref_clk | input | 1 | Reference clock; captures, differences and sums run on its rising edge |
| ref_rst_n | input | 1 | Active-low asynchronous reset of the reference-domain window logic |
| win_len_i | input | 5 | Requested number of differences per result (0 means 1, above 16 means 16) |
| temp_code_o | output | 14 | Most recent window sum |
| temp_vld_o | output | 1 | One-cycle strobe marking a new `temp_code_o` |

## Verification
Oscillator edges counted before reference edge k show up in a raw difference consumed three edges later. This follows from two synchronizer flops and one capture register. A result is due on the very edge that consumes the N-th difference of its window. The reference model in the bench therefore records the running edge total at every reference edge. It forms each expected sum from the entries three and 3+N edges back, and it latches the window length only at window starts. Oscillator bursts end well before the next rising reference edge. Outputs are compared on every falling edge, half a cycle after they settle, for the strobe and the held code alike.

// File: rtl/tcode_pkg.sv
`timescale 1ns/1ps
package tcode_pkg;

    // Window controller states
    typedef enum logic {
        ST_PRIME = 1'b0,   // discard the first difference after reset
        ST_ACCUM = 1'b1    // add one difference per reference cycle
    } win_state_e;

    // Default widths shared by the block
    localparam int unsigned EDGE_CNT_W = 10;
    localparam int unsigned WIN_MAX    = 16;

endpackage

// File: rtl/osc_edge_counter.sv
`timescale 1ns/1ps
module osc_edge_counter #(
    parameter int unsigned CW = 10
) (
    input  logic          osc_i,
    output logic [CW-1:0] gray_o
);

    // Free-running: initial value only, never reset or cleared
    logic [CW-1:0] bin_q  = '0;
    logic [CW-1:0] gray_q = '0;
    logic [CW-1:0] bin_nxt;

    always_comb begin
        bin_nxt = bin_q + 1'b1;
    end

    always_ff @(posedge osc_i) begin
        bin_q  <= bin_nxt;
        gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end

    assign gray_o = gray_q;

endmodule

// File: rtl/gray_sync_to_bin.sv
`timescale 1ns/1ps
module gray_sync_to_bin #(
    parameter int unsigned CW = 10
) (
    input  logic          clk_i,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] bin_o
);

    logic [CW-1:0] sync1_q = '0;
    logic [CW-1:0] sync2_q = '0;

    always_ff @(posedge clk_i) begin
        sync1_q <= gray_i;
        sync2_q <= sync1_q;
    end

    // Each binary bit is the parity of the Gray bits at and above it
    for (genvar b = 0; b < CW; b++) begin : g_g2b
        assign bin_o[b] = ^sync2_q[CW-1:b];
    end

endmodule

// File: rtl/delta_capture.sv
`timescale 1ns/1ps
module delta_capture #(
    parameter int unsigned CW = 10
) (
    input  logic          clk_i,
    input  logic [CW-1:0] bin_i,
    output logic [CW-1:0] diff_o
);

    logic [CW-1:0] cap_q  = '0;
    logic [CW-1:0] prev_q = '0;

    always_ff @(posedge clk_i) begin
        cap_q  <= bin_i;
        prev_q <= cap_q;
    end

    // Modulo 2^CW subtraction absorbs counter wraps
    assign diff_o = cap_q - prev_q;

endmodule

// File: rtl/window_accum.sv
`timescale 1ns/1ps
module window_accum
    import tcode_pkg::*;
#(
    parameter int unsigned DW   = 10,
    parameter int unsigned NMAX = 16,
    localparam int unsigned LENW = $clog2(NMAX + 1),
    localparam int unsigned ACCW = DW + $clog2(NMAX)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [DW-1:0]   diff_i,
    input  logic [LENW-1:0] win_len_i,
    output logic [ACCW-1:0] res_o,
    output logic            vld_o
);

    localparam logic [ACCW-1:0] DMAX = ACCW'((1 << DW) - 1);

    win_state_e      state_q, state_d;
    logic [LENW-1:0] len_q;
    logic [LENW-1:0] cnt_q;
    logic [ACCW-1:0] acc_q;
    logic [ACCW-1:0] res_q;
    logic            vld_q;
    logic [ACCW-1:0] sum_nxt;
    logic            last_diff;
    logic [LENW-1:0] len_req;

    function automatic logic [LENW-1:0] norm_len(input logic [LENW-1:0] w);
        if (w == '0)
            return LENW'(1);
        else if (32'(w) > NMAX)
            return LENW'(NMAX);
        else
            return w;
    endfunction

    always_comb begin
        len_req   = norm_len(win_len_i);
        sum_nxt   = acc_q + ACCW'(diff_i);
        last_diff = (cnt_q == len_q - 1'b1);
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= ST_PRIME;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_PRIME: state_d = ST_ACCUM;
            ST_ACCUM: state_d = ST_ACCUM;
            default:  state_d = ST_PRIME;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            len_q <= LENW'(1);
            cnt_q <= '0;
            acc_q <= '0;
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            unique case (state_q)
                ST_PRIME: begin
                    len_q <= len_req;
                    cnt_q <= '0;
                    acc_q <= '0;
                end
                ST_ACCUM: begin
                    if (last_diff) begin
                        res_q <= sum_nxt;
                        vld_q <= 1'b1;
                        acc_q <= '0;
                        cnt_q <= '0;
                        len_q <= len_req;
                    end else begin
                        acc_q <= sum_nxt;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    acc_q <= '0;
                end
            endcase
        end
    end

    assign res_o = res_q;
    assign vld_o = vld_q;

    // R4
    prime_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PRIME) |=> (state_q == ST_ACCUM && acc_q == '0 && !vld_q));

    // R6
    cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACCUM) |-> (cnt_q < len_q));

    // R5
    len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACCUM) |-> (len_q != '0 && 32'(len_q) <= NMAX));

    // R8
    len_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACCUM && cnt_q != '0) |-> $stable(len_q));

    // R9
    code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_q |-> $stable(res_q));

    // R10
    acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_q <= ACCW'(cnt_q) * DMAX);

endmodule

// File: rtl/osc_count_digitizer.sv
`timescale 1ns/1ps
module osc_count_digitizer
    import tcode_pkg::*;
#(
    parameter int unsigned CW   = EDGE_CNT_W,
    parameter int unsigned NMAX = WIN_MAX,
    localparam int unsigned LENW = $clog2(NMAX + 1),
    localparam int unsigned ACCW = CW + $clog2(NMAX)
) (
    input  logic            osc_i,
    input  logic            ref_clk,
    input  logic            ref_rst_n,
    input  logic [LENW-1:0] win_len_i,
    output logic [ACCW-1:0] temp_code_o,
    output logic            temp_vld_o
);

    logic [CW-1:0] gray_w;
    logic [CW-1:0] bin_w;
    logic [CW-1:0] diff_w;

    osc_edge_counter #(.CW(CW)) u_cnt (
        .osc_i  (osc_i),
        .gray_o (gray_w)
    );

    gray_sync_to_bin #(.CW(CW)) u_sync (
        .clk_i  (ref_clk),
        .gray_i (gray_w),
        .bin_o  (bin_w)
    );

    delta_capture #(.CW(CW)) u_delta (
        .clk_i  (ref_clk),
        .bin_i  (bin_w),
        .diff_o (diff_w)
    );

    window_accum #(.DW(CW), .NMAX(NMAX)) u_win (
        .clk_i     (ref_clk),
        .rst_ni    (ref_rst_n),
        .diff_i    (diff_w),
        .win_len_i (win_len_i),
        .res_o     (temp_code_o),
        .vld_o     (temp_vld_o)
    );

endmodule

// File: tb/osc_count_digitizer_tb_top.sv
`timescale 1ns/1ps
module osc_count_digitizer_tb_top;

    logic        ref_clk   = 1'b0;
    logic        ref_rst_n = 1'b0;
    logic        osc       = 1'b0;
    logic [4:0]  win       = 5'd4;
    logic [13:0] code;
    logic        vld;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int edges = 0;
    int hist[$];
    bit pend = 1'b1;
    int cur_n = 1;
    int wcnt = 0;
    int exp_res = 0;
    bit exp_vld = 1'b0;

    always #10 ref_clk = ~ref_clk;   // 50 MHz

    osc_count_digitizer dut_i (
        .osc_i       (osc),
        .ref_clk     (ref_clk),
        .ref_rst_n   (ref_rst_n),
        .win_len_i   (win),
        .temp_code_o (code),
        .temp_vld_o  (vld)
    );

    function automatic int eff_len(input int w);
        if (w == 0) return 1;
        if (w > 16) return 16;
        return w;
    endfunction

    // Behavioural model: running edge totals per reference edge
    always @(posedge ref_clk) begin
        int k;
        hist.push_back(edges);
        k = hist.size() - 1;
        if (!ref_rst_n) begin
            pend = 1'b1;
            exp_vld = 1'b0;
            exp_res = 0;
        end else if (pend) begin
            pend = 1'b0;
            cur_n = eff_len(int'(win));
            wcnt = 0;
            exp_vld = 1'b0;
        end else begin
            wcnt++;
            if (wcnt == cur_n) begin
                exp_vld = 1'b1;
                exp_res = hist[k-3] - hist[k-3-cur_n];
                wcnt = 0;
                cur_n = eff_len(int'(win));
            end else begin
                exp_vld = 1'b0;
            end
        end
    end

    task automatic check(input string tag);
        checks++;
        if (vld !== exp_vld) begin
            fails++;
            $display("FAIL %s: temp_vld_o=%0b expected %0b at %0t", tag, vld, exp_vld, $time);
        end
        checks++;
        if (code !== 14'(exp_res)) begin
            fails++;
            $display("FAIL %s: temp_code_o=%0d expected %0d at %0t", tag, code, exp_res, $time);
        end
    endtask

    task automatic run(input int n, input int w, input int lo, input int span,
                       input bit rst, input string tag);
        for (int c = 0; c < n; c++) begin
            int k;
            @(negedge ref_clk);
            check(tag);
            ref_rst_n = !rst;
            win = 5'(w);
            k = lo + ((span > 0) ? ((c * 7 + 3) % span) : 0);
            repeat (k) begin
                osc = 1'b1; #0.05;
                osc = 1'b0; #0.05;
                edges++;
            end
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL R6: watchdog expired, actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        run(5, 4, 0, 0, 1'b1, "R9");      // reset state, outputs zero
        run(24, 4, 7, 0, 1'b0, "R1");     // constant edge rate
        run(30, 4, 0, 30, 1'b0, "R7");    // back-to-back windows, varying rate
        run(20, 1, 0, 50, 1'b0, "R2");    // one difference per result
        run(40, 16, 45, 15, 1'b0, "R3");  // counter wraps inside windows
        run(40, 16, 80, 10, 1'b0, "R10"); // sums above 1023
        run(20, 0, 5, 20, 1'b0, "R5");    // zero acts as one
        run(40, 25, 10, 20, 1'b0, "R5");  // above 16 acts as 16
        run(5, 16, 20, 9, 1'b0, "R8");    // start a 16-window
        run(30, 3, 20, 9, 1'b0, "R8");    // change mid-window
        run(3, 2, 12, 5, 1'b1, "R9");     // reset mid-run
        run(20, 2, 12, 5, 1'b0, "R4");    // prime cycle then windows of 2
        run(20, 5, 30, 11, 1'b0, "R6");
        @(negedge ref_clk);
        check("R6");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule